// File: doc/BRIEF.md
# Staggered Half-Wave Dual-Pipe Dispatcher

This block starts instructions for 32-thread waves on execution pipes that are only 16 lanes wide. Each instruction holds its pipe for two cycles in a row: the lower 16 threads go first and the upper 16 threads follow in the next cycle. The block starts no more than one instruction per cycle. Because each instruction lasts two cycles, the two pipes end up one cycle apart: one pipe works on an upper half while the other starts a lower half. Seen from outside, this looks like dual issue.

Each wave presents a ready flag and an operation class (floating point or integer). The block keeps one busy bit per wave. A wave that has started an instruction cannot start another until its completion pulse arrives. Among the waves that are ready and not busy, the block picks by round robin, beginning with the wave after the one that started last. Each pipe has a fixed capability mask. A wave may only go to a pipe that is free in the next cycle and can run its class. A unified pipe runs exactly one class per cycle, and that class is shown on a per-pipe mode output. The ready, class and completion inputs are plain control levels and pulses. There is no handshake and no back-pressure: the block samples them every cycle, and a wave that is not picked simply stays ready.

Top module: `halfwave_dispatch`

## Requirements
- R1: While reset is held, and in the first cycle after it, every pipe is idle (`pipe_act`=0). No wave is marked busy, so the first decision after reset can pick wave 0.
- R2: A pipe that shows a lower half (`pipe_act`=1, `pipe_upper`=0) shows the upper half (`pipe_upper`=1) of the same wave, with the same class, in the very next cycle.
- R3: At most one pipe shows a lower half in any cycle, so at most one instruction starts per cycle.
- R4: From reset with all waves ready and floating point, the outputs follow this sequence:
  - wave 0 lower half on pipe 0 while pipe 1 is idle;
  - then wave 0 upper half on pipe 0 together with wave 1 lower half on pipe 1;
  - then wave 2 lower half on pipe 0 together with wave 1 upper half on pipe 1;
  - and so on, in the same staggered pattern.
- R5: A wave that has started is not started again until its completion pulse (`wave_done` bit high for one cycle) has been seen. The wave can start again in the second cycle after the pulse.
- R6: Among eligible waves, the first one taken is the one after the most recently started wave, counting upward and wrapping at the wave count.
- R7: A wave whose class is integer (`wave_int`=1) only goes to a pipe whose capability mask allows integer. `pipe_int` shows the class the pipe runs, for both halves. With the default mask (`PIPE_CAPS` bits [1:0]=11, [3:2]=01), pipe 0 is unified and pipe 1 runs floating point only.
- R8: When no wave is eligible, no lower half starts, but an upper half that is already due still appears in the next cycle.
- R9: A wave whose ready bit is low is never started, even if it is not busy.
- R10: When several pipes are free and can run the chosen wave's class, the lowest-numbered pipe gets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_rdy | input | NUM_WAVES | Per-wave flag: the wave has an instruction to start |
| wave_int | input | NUM_WAVES | Per-wave class: 1 integer, 0 floating point |
| wave_done | input | NUM_WAVES | Per-wave one-cycle completion pulse |
| pipe_act | output | NUM_PIPES | The pipe is working on a half this cycle |
| pipe_upper | output | NUM_PIPES | Half select: 0 lanes 0..15, 1 lanes 16..31 (valid when active) |
| pipe_wave | output | NUM_PIPES*log2(NUM_WAVES) | Wave number for each pipe, pipe p at bits [p*W +: W] (valid when active) |
| pipe_int | output | NUM_PIPES | Mode of each pipe this cycle: 1 integer, 0 floating point (valid when active) |

## Verification
The main pattern is a startup with every wave ready. It separates the staggered timeline from schemes that issue in parallel or start every other cycle. Completion pulses then release partial sets of waves in a chosen order, which tells true round robin apart from fixed priority. The bench also leaves all waves busy or not ready, to show that upper halves still drain while no lower half starts. Finally, mixed integer and floating-point sets on the asymmetric default pipes show an integer wave waiting for the unified pipe while a floating-point wave behind it takes the other pipe.

// File: rtl/halfwave_dispatch_pkg.sv
package halfwave_dispatch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOWER = 2'd1,
    PH_UPPER = 2'd2
  } half_phase_e;

  localparam int CLASS_FP  = 0;
  localparam int CLASS_INT = 1;
  localparam int CLASS_CNT = 2;
endpackage

// File: rtl/wave_busy_track.sv
module wave_busy_track #(
  parameter int NUM_WAVES = 4,
  localparam int WAVE_W = $clog2(NUM_WAVES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_vld,
  input  logic [WAVE_W-1:0]    start_id,
  input  logic [NUM_WAVES-1:0] done_pulse,
  output logic [NUM_WAVES-1:0] busy
);
  logic [NUM_WAVES-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (start_vld) set_vec[start_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~done_pulse) | set_vec;
  end

  // R5
  restart_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld |-> !busy[start_id]);

  // R5
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld |=> busy[$past(start_id)]);
endmodule

// File: rtl/wave_rr_pick.sv
module wave_rr_pick #(
  parameter int NUM_WAVES = 4,
  localparam int WAVE_W = $clog2(NUM_WAVES)
) (
  input  logic [NUM_WAVES-1:0] req,
  input  logic [WAVE_W-1:0]    last_id,
  output logic                 gnt_vld,
  output logic [WAVE_W-1:0]    gnt_id
);
  always_comb begin
    int idx;
    gnt_vld = 1'b0;
    gnt_id  = '0;
    idx     = 0;
    for (int k = 1; k <= NUM_WAVES; k++) begin
      idx = (int'(last_id) + k) % NUM_WAVES;
      if (!gnt_vld && req[idx]) begin
        gnt_vld = 1'b1;
        gnt_id  = WAVE_W'(idx);
      end
    end
  end

  // R9
  grant_has_request_chk: assert final (!gnt_vld || req[gnt_id]);
endmodule

// File: rtl/half_pipe_seq.sv
module half_pipe_seq
  import halfwave_dispatch_pkg::*;
#(
  parameter int WAVE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WAVE_W-1:0] launch_wave,
  input  logic              launch_int,
  output half_phase_e       phase,
  output logic [WAVE_W-1:0] cur_wave,
  output logic              cur_int,
  output logic              free_next
);
  assign free_next = (phase != PH_LOWER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cur_wave <= '0;
      cur_int  <= 1'b0;
    end else if (launch) begin
      phase    <= PH_LOWER;
      cur_wave <= launch_wave;
      cur_int  <= launch_int;
    end else if (phase == PH_LOWER) begin
      phase    <= PH_UPPER;
    end else begin
      phase    <= PH_IDLE;
    end
  end

  // R2
  lower_then_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOWER) |=> (phase == PH_UPPER) && $stable(cur_wave) && $stable(cur_int));

  // R3
  launch_on_busy_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (phase != PH_LOWER));
endmodule

// File: rtl/halfwave_dispatch.sv
module halfwave_dispatch
  import halfwave_dispatch_pkg::*;
#(
  parameter int NUM_WAVES = 4,
  parameter int NUM_PIPES = 2,
  parameter logic [NUM_PIPES*CLASS_CNT-1:0] PIPE_CAPS = 4'b0111
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_WAVES-1:0]                    wave_rdy,
  input  logic [NUM_WAVES-1:0]                    wave_int,
  input  logic [NUM_WAVES-1:0]                    wave_done,
  output logic [NUM_PIPES-1:0]                    pipe_act,
  output logic [NUM_PIPES-1:0]                    pipe_upper,
  output logic [NUM_PIPES*$clog2(NUM_WAVES)-1:0]  pipe_wave,
  output logic [NUM_PIPES-1:0]                    pipe_int
);
  localparam int WAVE_W = $clog2(NUM_WAVES);

  half_phase_e          phase   [NUM_PIPES];
  logic [WAVE_W-1:0]    cur_w   [NUM_PIPES];
  logic [NUM_PIPES-1:0] free_nx;
  logic [NUM_PIPES-1:0] cur_i;
  logic [NUM_PIPES-1:0] launch;
  logic [NUM_PIPES-1:0] lower_now;
  logic [NUM_WAVES-1:0] busy;
  logic [NUM_WAVES-1:0] fits;
  logic [NUM_WAVES-1:0] req;
  logic                 gnt_vld;
  logic [WAVE_W-1:0]    gnt_id;
  logic [WAVE_W-1:0]    last_id;
  logic                 start_vld;

  // Eligibility: ready, idle, and some free pipe able to run the wave's class
  always_comb begin
    fits = '0;
    for (int w = 0; w < NUM_WAVES; w++) begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        if (free_nx[p] && PIPE_CAPS[p*CLASS_CNT + int'(wave_int[w])]) fits[w] = 1'b1;
      end
    end
  end

  assign req = wave_rdy & ~busy & fits;

  wave_rr_pick #(.NUM_WAVES(NUM_WAVES)) u_pick (
    .req     (req),
    .last_id (last_id),
    .gnt_vld (gnt_vld),
    .gnt_id  (gnt_id)
  );

  // Lowest-numbered free, capable pipe takes the granted wave
  always_comb begin
    launch = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (gnt_vld && launch == '0 && free_nx[p] &&
          PIPE_CAPS[p*CLASS_CNT + int'(wave_int[gnt_id])])
        launch[p] = 1'b1;
    end
  end

  assign start_vld = |launch;

  always_ff @(posedge clk) begin
    if (!rst_n)         last_id <= WAVE_W'(NUM_WAVES - 1);
    else if (start_vld) last_id <= gnt_id;
  end

  wave_busy_track #(.NUM_WAVES(NUM_WAVES)) u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_vld  (start_vld),
    .start_id   (gnt_id),
    .done_pulse (wave_done),
    .busy       (busy)
  );

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    half_pipe_seq #(.WAVE_W(WAVE_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch[p]),
      .launch_wave (gnt_id),
      .launch_int  (wave_int[gnt_id]),
      .phase       (phase[p]),
      .cur_wave    (cur_w[p]),
      .cur_int     (cur_i[p]),
      .free_next   (free_nx[p])
    );
    assign pipe_act[p]                    = (phase[p] != PH_IDLE);
    assign pipe_upper[p]                  = (phase[p] == PH_UPPER);
    assign pipe_wave[p*WAVE_W +: WAVE_W]  = cur_w[p];
    assign pipe_int[p]                    = cur_i[p];
    assign lower_now[p]                   = (phase[p] == PH_LOWER);

    // R7
    class_matches_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[p] != PH_IDLE) |-> PIPE_CAPS[p*CLASS_CNT + int'(cur_i[p])]);
  end

  // R3
  single_lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lower_now) <= 1);

  // R8
  idle_when_no_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (lower_now == '0));

  // R5
  done_frees_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wave_done & busy & ~launch_mask(start_vld, gnt_id))) |=> (busy != '1) || !rst_n);

  function automatic logic [NUM_WAVES-1:0] launch_mask(input logic v, input logic [WAVE_W-1:0] id);
    launch_mask = '0;
    if (v) launch_mask[id] = 1'b1;
  endfunction
endmodule

// File: tb/halfwave_dispatch_bench.sv
module halfwave_dispatch_bench;
  localparam int NW = 4;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] wave_rdy = '0;
  logic [NW-1:0] wave_int = '0;
  logic [NW-1:0] wave_done = '0;
  logic [NP-1:0] pipe_act;
  logic [NP-1:0] pipe_upper;
  logic [NP*2-1:0] pipe_wave;
  logic [NP-1:0] pipe_int;

  always #2 clk = ~clk;

  halfwave_dispatch u_halfwave_dispatch (
    .clk(clk), .rst_n(rst_n), .wave_rdy(wave_rdy), .wave_int(wave_int),
    .wave_done(wave_done), .pipe_act(pipe_act), .pipe_upper(pipe_upper),
    .pipe_wave(pipe_wave), .pipe_int(pipe_int)
  );

  typedef struct {
    int    stamp;
    int    st [NP];
    int    wv [NP];
    bit    it [NP];
    string req;
  } exp_t;

  exp_t q[$];
  int   edges  = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   driver_done = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  function automatic int state_of(int p);
    if (!pipe_act[p]) return 0;
    return pipe_upper[p] ? 2 : 1;
  endfunction

  // Monitor: compare outputs mid-cycle against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp == edges) begin
      exp_t e;
      bit   bad;
      e = q.pop_front();
      checks++;
      bad = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (state_of(p) != e.st[p]) bad = 1'b1;
        if (e.st[p] != 0 && (int'(pipe_wave[p*2 +: 2]) != e.wv[p] || pipe_int[p] != e.it[p])) bad = 1'b1;
      end
      if (bad) begin
        fails++;
        $display("FAIL %s edge %0d: actual p0 st%0d w%0d i%0d p1 st%0d w%0d i%0d expected p0 st%0d w%0d i%0d p1 st%0d w%0d i%0d",
                 e.req, edges, state_of(0), pipe_wave[1:0], pipe_int[0], state_of(1), pipe_wave[3:2], pipe_int[1],
                 e.st[0], e.wv[0], e.it[0], e.st[1], e.wv[1], e.it[1]);
      end
    end
  end

  // Driver: set inputs for this cycle and queue the outputs due after the next edge
  task automatic step(input logic [NW-1:0] rdy, input logic [NW-1:0] ty, input logic [NW-1:0] dn,
                      input int s0, input int w0, input bit i0,
                      input int s1, input int w1, input bit i1, input string req);
    exp_t e;
    wave_rdy  = rdy;
    wave_int  = ty;
    wave_done = dn;
    e.stamp = edges + 1;
    e.st[0] = s0; e.wv[0] = w0; e.it[0] = i0;
    e.st[1] = s1; e.wv[1] = w1; e.it[1] = i1;
    e.req   = req;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still going, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      checks++;
      if (pipe_act != '0) begin
        fails++;
        $display("FAIL R1 reset: actual pipe_act %b expected 00", pipe_act);
      end
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 R4 staggered start, all floating point
    step(4'hF, 4'h0, 4'h0, 1,0,0, 0,0,0, "R1");
    step(4'hF, 4'h0, 4'h0, 2,0,0, 1,1,0, "R4");
    step(4'hF, 4'h0, 4'h0, 1,2,0, 2,1,0, "R4");
    step(4'hF, 4'h0, 4'h0, 2,2,0, 1,3,0, "R4");
    step(4'hF, 4'h0, 4'h0, 0,0,0, 2,3,0, "R8");
    step(4'hF, 4'h0, 4'h0, 0,0,0, 0,0,0, "R5");
    // R5 release waves 1 and 2; visible two cycles later
    step(4'hF, 4'h0, 4'h6, 0,0,0, 0,0,0, "R5");
    step(4'hF, 4'h0, 4'h0, 1,1,0, 0,0,0, "R6");
    step(4'hF, 4'h0, 4'h0, 2,1,0, 1,2,0, "R6");
    step(4'hF, 4'h0, 4'h0, 0,0,0, 2,2,0, "R8");
    // R6 release 0,1,3 after wave 2 started last: order 3,0,1
    step(4'hF, 4'h0, 4'hB, 0,0,0, 0,0,0, "R5");
    step(4'hF, 4'h0, 4'h0, 1,3,0, 0,0,0, "R6");
    step(4'hF, 4'h0, 4'h0, 2,3,0, 1,0,0, "R6");
    step(4'hF, 4'h0, 4'h0, 1,1,0, 2,0,0, "R6");
    step(4'hF, 4'h0, 4'h0, 2,1,0, 0,0,0, "R2");
    step(4'hF, 4'h0, 4'h0, 0,0,0, 0,0,0, "R5");
    // R9 not-ready waves stay idle
    step(4'h0, 4'h0, 4'hF, 0,0,0, 0,0,0, "R9");
    step(4'h0, 4'h0, 4'h0, 0,0,0, 0,0,0, "R9");
    // R7 integer wave 1 waits for the unified pipe 0
    step(4'hA, 4'h2, 4'h0, 1,3,0, 0,0,0, "R10");
    step(4'hA, 4'h2, 4'h0, 2,3,0, 0,0,0, "R7");
    step(4'hA, 4'h2, 4'h0, 1,1,1, 0,0,0, "R7");
    step(4'hA, 4'h2, 4'h0, 2,1,1, 0,0,0, "R7");
    step(4'h0, 4'h2, 4'h0, 0,0,0, 0,0,0, "R9");
    step(4'h0, 4'h0, 4'hF, 0,0,0, 0,0,0, "R9");
    // R7 R10 mixed classes: waves 0,1 integer, 2,3 floating point
    step(4'hF, 4'h3, 4'h0, 1,2,0, 0,0,0, "R10");
    step(4'hF, 4'h3, 4'h0, 2,2,0, 1,3,0, "R10");
    step(4'hF, 4'h3, 4'h0, 1,0,1, 2,3,0, "R7");
    step(4'hF, 4'h3, 4'h0, 2,0,1, 0,0,0, "R7");
    step(4'hF, 4'h3, 4'h0, 1,1,1, 0,0,0, "R7");
    step(4'hF, 4'h3, 4'h0, 2,1,1, 0,0,0, "R2");
    step(4'hF, 4'h3, 4'h0, 0,0,0, 0,0,0, "R8");
    wave_rdy = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3 scoreboard: actual %0d pending expected 0", q.size());
    end
    driver_done = 1'b1;
    summary();
  end
endmodule